// File: doc/BRIEF.md
# Core hibernate and wakeup controller

This block decides when the processor core may lose its supply and when it gets it back. Software requests hibernate by clearing an active-low run bit in a control register. On the next clock edge both the core-clock and system-clock enables drop. The regulator-enable output then falls, which tells the external regulator to switch the core supply off.

While the block hibernates, the regulator-enable output is the OR of four wake pins, each qualified by its own enable bit. The output follows those pins level for level, so the regulator powers up as soon as an enabled pin is asserted. The regulator answers on an active-low power-good input. That input is synchronised, inverted and reported as a voltage-stable status bit. The block returns to the run state, and turns its clock enables back on, only when an enabled wake source is active and the voltage-stable bit is set. A hardware reset always returns the block to the run state.

The block runs on an always-on clock. Its two registers are reached through a single-cycle interface with a write strobe, an address, write data and combinational read data.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset the control register reads 0x01: run bit (bit 0) is 1 and the wake enables (bits 4:1, pin i at bit i+1) are 0. Both clock enables are 1 and the regulator enable is 1. The regulator enable stays 1 whenever the block is in the run state.
- R2: A write to address 0 with bit 0 clear makes the core-clock and system-clock enables both 0 from the clock edge that takes the write.
- R3: While hibernating, the regulator enable is the OR, over the four pins, of pin level AND its enable bit. The pin levels are taken after a two-flop synchroniser, so a pin change shows at the output two clock edges after it is presented, both on rising and on falling.
- R4: While hibernating, a wake pin whose enable bit is 0 has no effect on the regulator enable or on the clock enables.
- R5: Status bit 0 (address 1) reads 1 exactly when the power-good input, delayed by two clock edges, is low.
- R6: While hibernating, if the regulator enable is 1 and the voltage-stable bit is 1 at a clock edge, the run bit returns to 1 and both clock enables turn on from that edge; the wake enables keep their values. The block stays in hibernate while the voltage-stable bit is 0.
- R7: Reset asserted during hibernate returns the block to the run state, with the clock enables on and the control register at 0x01, whatever the wake enables were.
- R8: Status bits 4:1 read the synchronised wake pin levels (pin i at bit i+1). Writes to address 1 are ignored. Addresses 2 and 3 read 0.
- R9: Read data is combinational from the address, and a written control value can be read back in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| wake_pin_i | input | 4 | Asynchronous wake pins, active high |
| pgood_n_i | input | 1 | Asynchronous active-low power-good from the regulator |
| cclk_en_o | output | 1 | Core-clock enable |
| sclk_en_o | output | 1 | System-clock enable |
| regulator_en_o | output | 1 | Enable to the external core regulator |

## Verification
The hard case is a wake source that is active while the supply has not yet settled. In that window the regulator enable must be high but the clocks must stay off. It is hard to reach because the bench must hold power-good deasserted after the wake pin rises. The stimulus therefore enters hibernate with power-good withdrawn, raises an enabled pin, drops it again before power-good returns to show the level-following output, and then raises it once more before releasing power-good. Separate sequences toggle a disabled pin in the same state and pulse reset in the middle of hibernate.

// File: rtl/hw_pkg.sv
// Package: shared constants and the run/sleep state for the hibernate block.
// Assumes: address decoding and field positions are fixed by this package.
package hw_pkg;
    localparam int unsigned CTRL_ADDR = 0;
    localparam int unsigned STAT_ADDR = 1;
    localparam int unsigned RUN_BIT   = 0;
    localparam int unsigned VST_BIT   = 0;
    localparam int unsigned FIELD_LSB = 1;

    typedef enum logic {
        PWR_SLEEP = 1'b0,
        PWR_RUN   = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/hw_sync.sv
// Module: per-bit two-flop synchroniser with a selectable reset level.
// Assumes: each input bit is independent; no bus coherency is implied.
module hw_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                sync_q <= RST_VAL;
            end else begin
                meta_q <= d_i[i];
                sync_q <= meta_q;
            end
        end
        assign q_o[i] = sync_q;
    end
endmodule

// File: rtl/hw_wake.sv
// Module: wake combining; masks the synchronised pins with their enables,
// forms the regulator enable and the request to leave hibernate.
// Assumes: inputs are already synchronous to the block clock.
module hw_wake #(
    parameter int NPIN = 4
) (
    input  hw_pkg::pwr_state_e state_i,
    input  logic [NPIN-1:0]    pin_i,
    input  logic [NPIN-1:0]    en_i,
    input  logic               vstable_i,
    output logic               reg_en_o,
    output logic               exit_o
);
    import hw_pkg::*;

    logic [NPIN-1:0] masked;
    logic            wake_any;

    for (genvar i = 0; i < NPIN; i++) begin : g_mask
        assign masked[i] = pin_i[i] & en_i[i];
    end

    // Combine the qualified pins into one wake level.
    always_comb wake_any = |masked;

    // Regulator is held on in run state, follows wake level in sleep.
    always_comb reg_en_o = (state_i == PWR_RUN) | wake_any;

    // Leave sleep once a wake is present and the supply reports stable.
    always_comb exit_o = (state_i == PWR_SLEEP) & wake_any & vstable_i;
endmodule

// File: rtl/hw_regs.sv
// Module: control and status registers for the hibernate block.
// Control: bit RUN_BIT is the active-low hibernate request, the next NPIN
// bits are wake enables. Status: voltage-stable bit and synchronised pins.
// Assumes: a software write has priority over a wake exit in the same cycle.
module hw_regs #(
    parameter int NPIN   = 4,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic               exit_i,
    input  logic [NPIN-1:0]    pin_i,
    input  logic               vstable_i,
    output hw_pkg::pwr_state_e state_o,
    output logic [NPIN-1:0]    en_o
);
    import hw_pkg::*;

    localparam int FIELD_MSB = FIELD_LSB + NPIN - 1;

    pwr_state_e      state_q;
    logic [NPIN-1:0] en_q;
    logic            ctrl_hit;
    logic            unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:FIELD_MSB+1];

    // Decode a write to the control register.
    always_comb ctrl_hit = we_i && (addr_i == ADDR_W'(CTRL_ADDR));

    // Control register state: reset to run, write, or wake exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_RUN;
            en_q    <= '0;
        end else if (ctrl_hit) begin
            state_q <= pwr_state_e'(wdata_i[RUN_BIT]);
            en_q    <= wdata_i[FIELD_MSB:FIELD_LSB];
        end else if (exit_i) begin
            state_q <= PWR_RUN;
        end
    end

    // Combinational read mux.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(CTRL_ADDR)) begin
            rdata_o[RUN_BIT]             = state_q;
            rdata_o[FIELD_MSB:FIELD_LSB] = en_q;
        end else if (addr_i == ADDR_W'(STAT_ADDR)) begin
            rdata_o[VST_BIT]             = vstable_i;
            rdata_o[FIELD_MSB:FIELD_LSB] = pin_i;
        end
    end

    assign state_o = state_q;
    assign en_o    = en_q;

    // Remember that the previous edge was in reset (assertion support).
    logic rst_prev_q;
    always_ff @(posedge clk) rst_prev_q <= !rst_n;

    // R7: the edge after reset leaves the block running with enables cleared.
    a_r7_reset_runs: assert property (@(posedge clk) disable iff (!rst_n)
        rst_prev_q |-> (state_q == PWR_RUN && en_q == '0));

    // R6: a wake exit without a competing write returns to run.
    a_r6_exit_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_i && !ctrl_hit) |=> (state_q == PWR_RUN));
endmodule

// File: rtl/hib_wake_ctrl.sv
// Module: top of the core hibernate and wakeup controller.
// Gates the core and system clock enables from the run bit, drives the
// regulator enable from the wake logic, and synchronises pins and power-good.
// Assumes: clk is always on; wake pins and power-good are asynchronous.
module hib_wake_ctrl #(
    parameter int NPIN   = 4,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPIN-1:0]   wake_pin_i,
    input  logic              pgood_n_i,
    output logic              cclk_en_o,
    output logic              sclk_en_o,
    output logic              regulator_en_o
);
    import hw_pkg::*;

    logic [NPIN-1:0] pin_sync;
    logic            pgood_n_sync;
    logic            vstable;
    logic            exit_req;
    logic [NPIN-1:0] wake_en;
    pwr_state_e      state;

    hw_sync #(.W(NPIN), .RST_VAL(1'b0)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (wake_pin_i),
        .q_o   (pin_sync)
    );

    hw_sync #(.W(1), .RST_VAL(1'b1)) u_pg_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pgood_n_i),
        .q_o   (pgood_n_sync)
    );

    // Voltage is stable when the synchronised active-low good is low.
    always_comb vstable = ~pgood_n_sync;

    hw_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .exit_i    (exit_req),
        .pin_i     (pin_sync),
        .vstable_i (vstable),
        .state_o   (state),
        .en_o      (wake_en)
    );

    hw_wake #(.NPIN(NPIN)) u_wake (
        .state_i   (state),
        .pin_i     (pin_sync),
        .en_i      (wake_en),
        .vstable_i (vstable),
        .reg_en_o  (regulator_en_o),
        .exit_o    (exit_req)
    );

    // Both clock domains are enabled exactly in the run state.
    always_comb begin
        cclk_en_o = (state == PWR_RUN);
        sclk_en_o = (state == PWR_RUN);
    end

    // R2: clearing the run bit turns both clock enables off next cycle.
    a_r2_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(CTRL_ADDR) && !reg_wdata[RUN_BIT])
        |=> (!cclk_en_o && !sclk_en_o));

    // R1: a running core always has its regulator enabled.
    a_r1_run_powered: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en_o |-> regulator_en_o);

    // R4: in sleep, with no enabled pin active, the regulator stays off.
    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cclk_en_o && (pin_sync & wake_en) == '0) |-> !regulator_en_o);

    // R6: no return to run while the supply is not yet stable.
    a_r6_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cclk_en_o && !vstable && !reg_we) |=> !cclk_en_o);
endmodule

// File: tb/sim_hib_wake_ctrl.sv
// Bench: behavioural reference model compared on every clock, plus directed
// scenarios for each requirement.
module sim_hib_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [3:0] wake_pin_i;
    logic       pgood_n_i;
    logic       cclk_en_o;
    logic       sclk_en_o;
    logic       regulator_en_o;

    int total = 0;
    int bad   = 0;
    bit run   = 0;

    always #5 clk = ~clk;

    hib_wake_ctrl u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .wake_pin_i     (wake_pin_i),
        .pgood_n_i      (pgood_n_i),
        .cclk_en_o      (cclk_en_o),
        .sclk_en_o      (sclk_en_o),
        .regulator_en_o (regulator_en_o)
    );

    // Reference model state.
    bit         m_run = 1;
    bit [3:0]   m_en  = 0;
    bit [3:0]   pin_q[$] = '{4'h0, 4'h0};
    bit         pg_q[$]  = '{1'b1, 1'b1};

    function automatic bit m_regen();
        return m_run || ((pin_q[0] & m_en) != 0);
    endfunction

    function automatic bit [7:0] m_rdata(input bit [1:0] a);
        if (a == 0) return {3'b0, m_en, m_run};
        if (a == 1) return {3'b0, pin_q[0], ~pg_q[0]};
        return 8'h00;
    endfunction

    // Model update at each edge, from inputs held stable since the negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 1; m_en = 0;
            pin_q = '{4'h0, 4'h0};
            pg_q  = '{1'b1, 1'b1};
        end else begin
            if (reg_we && reg_addr == 0) begin
                m_run = reg_wdata[0];
                m_en  = reg_wdata[4:1];
            end else if (!m_run && ((pin_q[0] & m_en) != 0) && !pg_q[0]) begin
                m_run = 1;
            end
            pin_q.push_back(wake_pin_i); void'(pin_q.pop_front());
            pg_q.push_back(pgood_n_i);   void'(pg_q.pop_front());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always begin
        @(posedge clk);
        #2;
        if (run) begin
            chk("R2/R6 cclk_en", cclk_en_o, m_run);
            chk("R2/R6 sclk_en", sclk_en_o, m_run);
            chk("R3 regulator_en", regulator_en_o, m_regen());
            chk("R8 rdata", reg_rdata, m_rdata(reg_addr));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 0;
    endtask

    task automatic rd(input bit [1:0] a, output bit [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit [7:0] d;
        rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        wake_pin_i = 0; pgood_n_i = 1;
        tick(3);
        rst_n = 1;
        run = 1;
        tick(1);

        // R1: reset state.
        rd(0, d); chk("R1 ctrl reset", d, 8'h01);
        chk("R1 cclk_en", cclk_en_o, 1);
        chk("R1 sclk_en", sclk_en_o, 1);
        chk("R1 regulator_en", regulator_en_o, 1);

        // R5: power-good latency of two edges.
        pgood_n_i = 0;
        tick(1); rd(1, d); chk("R5 vstable after 1 edge", d[0], 0);
        tick(1); rd(1, d); chk("R5 vstable after 2 edges", d[0], 1);

        // R2: enter hibernate, pins 0 and 2 enabled.
        wr(0, 8'h0A);
        chk("R2 cclk_en off", cclk_en_o, 0);
        chk("R2 sclk_en off", sclk_en_o, 0);
        chk("R2 regulator_en off", regulator_en_o, 0);
        rd(0, d); chk("R9 ctrl readback", d, 8'h0A);
        pgood_n_i = 1;
        tick(2);
        rd(1, d); chk("R5 vstable dropped", d[0], 0);

        // R4: disabled pin 1 has no effect; R8 shows its level.
        wake_pin_i = 4'b0010;
        tick(4);
        chk("R4 regulator_en with disabled pin", regulator_en_o, 0);
        chk("R4 cclk_en with disabled pin", cclk_en_o, 0);
        rd(1, d); chk("R8 status pin field", d, 8'h04);
        wake_pin_i = 0;
        tick(2);

        // R3 and R6: enabled pin 2 while supply not yet stable.
        wake_pin_i = 4'b0100;
        tick(1); chk("R3 regen after 1 edge", regulator_en_o, 0);
        tick(1); chk("R3 regen after 2 edges", regulator_en_o, 1);
        tick(3); chk("R6 stays asleep without vstable", cclk_en_o, 0);
        wake_pin_i = 0;
        tick(1); chk("R3 regen hold 1 edge", regulator_en_o, 1);
        tick(1); chk("R3 regen follows fall", regulator_en_o, 0);
        wake_pin_i = 4'b0100;
        tick(2); chk("R3 regen rises again", regulator_en_o, 1);
        pgood_n_i = 0;
        tick(2); chk("R6 not yet running", cclk_en_o, 0);
        tick(1); chk("R6 running after stable", cclk_en_o, 1);
        chk("R6 sclk running", sclk_en_o, 1);
        rd(0, d); chk("R6 enables kept", d, 8'h0B);
        wake_pin_i = 0;
        tick(3); chk("R1 regen held in run", regulator_en_o, 1);

        // R7: reset during hibernate.
        wr(0, 8'h1E);
        pgood_n_i = 1;
        tick(3);
        chk("R7 asleep before reset", cclk_en_o, 0);
        rst_n = 0;
        tick(1);
        rst_n = 1;
        chk("R7 cclk after reset", cclk_en_o, 1);
        rd(0, d); chk("R7 ctrl after reset", d, 8'h01);

        // R8: status writes ignored, spare addresses read zero.
        wr(1, 8'hFF);
        rd(0, d); chk("R8 ctrl unchanged by status write", d, 8'h01);
        rd(2, d); chk("R8 addr 2 reads zero", d, 8'h00);
        rd(3, d); chk("R8 addr 3 reads zero", d, 8'h00);

        tick(2);
        run = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule